// File: doc/BRIEF.md
# Inclusive Shared-Cache Presence Directory

This block keeps the tags and per-core holder bits of a shared cache that is inclusive of the private caches of several cores. Each request arrives with a core number, a byte address and a read/exclusive flag. The block looks the line up in a set-associative tag store and answers with one of two outcomes:

- On a hit, it issues one snoop to those other cores whose holder bit is set.
- On a miss, it allocates a way. If that way held a line, the block back-invalidates every core still marked as holding the old line.

Inclusion makes a miss proof that no core holds the line, so a miss never snoops. A set bit is only a hint that the core may hold the line. A core that drops a line silently keeps its bit.

One request is processed at a time. The request port is busy from acceptance until the snoop and back-invalidate have been issued, together with a one-cycle response pulse. Line data, the private caches and the memory side are outside this block.

Top module: `cache_presence_dir`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `snp_valid` and `binv_valid` are 0, and every way is invalid, so the first access to any line misses.
- R2: On a miss (`rsp_hit`=0) no snoop is issued, and the filled line's holder bits become exactly the requesting core's bit (bit index = core number).
- R3: A read (`req_excl`=0) that hits snoops the cores whose holder bit is set, excluding the requester, with `snp_inv`=0. It then adds the requester's bit to the line.
- R4: An exclusive request (`req_excl`=1) that hits snoops every other core whose bit is set, with `snp_inv`=1, and leaves only the requester's bit set.
- R5: `snp_valid` pulses only when the snoop mask is non-zero. `snp_addr` then carries the request's full address.
- R6: A miss fills the lowest-numbered invalid way of the set. If every way is valid, it fills the least recently accessed way, where both hits and fills count as accesses.
- R7: When the replaced way was valid with non-zero holder bits, `binv_valid` pulses with `binv_mask` set to those bits. `binv_addr` is set to the old line's address with the offset bits zero.
- R8: `rsp_evict` is 1 exactly when a miss replaced a valid line.
- R9: The handshake runs as follows:
  - `req_ready` is 1 only when idle.
  - A request is taken on a clock edge with `req_valid` and `req_ready` high.
  - `req_ready` then stays 0 for two cycles.
  - The response pulse occurs in the second of those cycles and lasts exactly one cycle: `rsp_valid`, plus any snoop or back-invalidate pulse.
  - `rsp_core` echoes the requester during the pulse.
- R10: The set index is address bits [OFF_W +: log2(SETS)], and the tag is the bits above them. The offset bits are ignored for lookup, so any two addresses in one line hit the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_core | input | log2(NCORES) | Requesting core number |
| req_addr | input | ADDR_W | Byte address of the request |
| req_excl | input | 1 | 1 = exclusive (write) request, 0 = read |
| snp_valid | output | 1 | Snoop pulse to the cores in `snp_mask` |
| snp_mask | output | NCORES | Cores to snoop |
| snp_inv | output | 1 | Snoop invalidates (exclusive request) |
| snp_addr | output | ADDR_W | Address being snooped |
| binv_valid | output | 1 | Back-invalidate pulse |
| binv_mask | output | NCORES | Cores that must drop the replaced line |
| binv_addr | output | ADDR_W | Line address of the replaced line |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_core | output | log2(NCORES) | Requester of this result |
| rsp_hit | output | 1 | Line was present |
| rsp_evict | output | 1 | A valid line was replaced |

## Verification
The bench builds the block with four cores, four sets, two ways, 12-bit addresses and 4 offset bits. With so few sets and ways, a handful of line addresses keeps every set full. Replacements, back-invalidates of lines shared by several cores, and stale holder bits then occur on most random requests. Directed steps place hits at different offsets of one line and build up a multi-holder line. They then force an exclusive hit and evict lines in a known recency order.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_DONE = 2'd2
  } dir_state_e;
endpackage

// File: rtl/dir_tag_array.sv
module dir_tag_array #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int NCORES = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_en,
  input  logic [SET_W-1:0]        lk_set,
  input  logic [TAG_W-1:0]        lk_tag,
  output logic [WAYS-1:0]         hit_vec,
  output logic [WAYS-1:0]         rd_valid,
  output logic [WAYS*TAG_W-1:0]   rd_tag,
  output logic [WAYS*NCORES-1:0]  rd_pres,
  input  logic                    wr_en,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [NCORES-1:0]       wr_pres
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [NCORES-1:0] pres_q  [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[lk_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[lk_set][wr_way]  <= wr_tag;
      pres_q[lk_set][wr_way] <= wr_pres;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_valid[w]                    = valid_q[lk_set][w];
    assign rd_tag[w*TAG_W +: TAG_W]       = tag_q[lk_set][w];
    assign rd_pres[w*NCORES +: NCORES]    = pres_q[lk_set][w];
    assign hit_vec[w] = lk_en && valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  // R10: one line address can occupy at most one way of its set
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/dir_lru.sv
module dir_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  function automatic logic [WAY_W-1:0] aged(input logic [WAY_W-1:0] cur,
                                            input logic [WAY_W-1:0] ref_age,
                                            input logic             is_touched);
    if (is_touched)          return '0;
    else if (cur < ref_age)  return cur + 1'b1;
    else                     return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[lk_set][w] <= aged(age_q[lk_set][w], age_q[lk_set][touch_way],
                                 WAY_W'(w) == touch_way);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[lk_set][w] == WAY_W'(WAYS - 1));
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (oldest_vec[w]) lru_way = WAY_W'(w);
  end

  // R6: the ages of a set stay a permutation, so exactly one way is oldest
  a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/dir_presence.sv
module dir_presence #(
  parameter int NCORES = 4,
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              hit,
  input  logic              excl,
  input  logic [CORE_W-1:0] core,
  input  logic [NCORES-1:0] cur_pres,
  output logic [NCORES-1:0] snp_mask,
  output logic [NCORES-1:0] next_pres
);
  function automatic logic [NCORES-1:0] core_bit(input logic [CORE_W-1:0] c);
    logic [NCORES-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  logic [NCORES-1:0] self_bit;
  assign self_bit  = core_bit(core);
  assign snp_mask  = hit ? (cur_pres & ~self_bit) : '0;
  assign next_pres = (hit && !excl) ? (cur_pres | self_bit) : self_bit;
endmodule

// File: rtl/cache_presence_dir.sv
module cache_presence_dir
  import dir_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_excl,
  output logic              snp_valid,
  output logic [NCORES-1:0] snp_mask,
  output logic              snp_inv,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              binv_valid,
  output logic [NCORES-1:0] binv_mask,
  output logic [ADDR_W-1:0] binv_addr,
  output logic              rsp_valid,
  output logic [CORE_W-1:0] rsp_core,
  output logic              rsp_hit,
  output logic              rsp_evict
);
  dir_state_e        st_q;
  logic [CORE_W-1:0] rq_core_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic              rq_excl_q;

  logic                   look;
  logic [SET_W-1:0]       lk_set;
  logic [TAG_W-1:0]       lk_tag;
  logic [WAYS-1:0]        hit_vec;
  logic [WAYS-1:0]        rd_valid;
  logic [WAYS*TAG_W-1:0]  rd_tag;
  logic [WAYS*NCORES-1:0] rd_pres;
  logic                   hit;
  logic [WAY_W-1:0]       hit_way, free_way, lru_way, vict_way, sel_way;
  logic                   any_free;
  logic [NCORES-1:0]      hit_pres, vict_pres, cur_pres, snp_mask_w, next_pres;
  logic [TAG_W-1:0]       vict_tag;
  logic                   vict_valid;

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  assign look      = (st_q == ST_LOOK);
  assign req_ready = (st_q == ST_IDLE);
  assign lk_set    = rq_addr_q[OFF_W +: SET_W];
  assign lk_tag    = rq_addr_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rq_core_q <= '0;
      rq_addr_q <= '0;
      rq_excl_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q      <= ST_LOOK;
          rq_core_q <= req_core;
          rq_addr_q <= req_addr;
          rq_excl_q <= req_excl;
        end
        ST_LOOK: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dir_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .NCORES(NCORES)) u_tags (
    .clk, .rst_n,
    .lk_en(look), .lk_set, .lk_tag,
    .hit_vec, .rd_valid, .rd_tag, .rd_pres,
    .wr_en(look), .wr_way(sel_way), .wr_tag(lk_tag), .wr_pres(next_pres)
  );

  dir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk, .rst_n, .lk_set,
    .touch_en(look), .touch_way(sel_way), .lru_way
  );

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!rd_valid[w]) free_way = WAY_W'(w);
  end

  assign hit        = |hit_vec;
  assign any_free   = ~&rd_valid;
  assign vict_way   = any_free ? free_way : lru_way;
  assign sel_way    = hit ? hit_way : vict_way;
  assign hit_pres   = rd_pres[hit_way*NCORES +: NCORES];
  assign vict_pres  = rd_pres[vict_way*NCORES +: NCORES];
  assign vict_tag   = rd_tag[vict_way*TAG_W +: TAG_W];
  assign vict_valid = rd_valid[vict_way];
  assign cur_pres   = hit ? hit_pres : '0;

  dir_presence #(.NCORES(NCORES)) u_pres (
    .hit, .excl(rq_excl_q), .core(rq_core_q), .cur_pres,
    .snp_mask(snp_mask_w), .next_pres
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_core   <= '0;
      rsp_hit    <= 1'b0;
      rsp_evict  <= 1'b0;
      snp_valid  <= 1'b0;
      snp_mask   <= '0;
      snp_inv    <= 1'b0;
      snp_addr   <= '0;
      binv_valid <= 1'b0;
      binv_mask  <= '0;
      binv_addr  <= '0;
    end else begin
      rsp_valid  <= look;
      snp_valid  <= look && hit && (|snp_mask_w);
      binv_valid <= look && !hit && vict_valid && (|vict_pres);
      if (look) begin
        rsp_core  <= rq_core_q;
        rsp_hit   <= hit;
        rsp_evict <= !hit && vict_valid;
        snp_mask  <= snp_mask_w;
        snp_inv   <= rq_excl_q;
        snp_addr  <= rq_addr_q;
        binv_mask <= (!hit && vict_valid) ? vict_pres : '0;
        binv_addr <= line_addr(vict_tag, lk_set);
      end
    end
  end

  // R3: a snoop never targets the requesting core
  a_r3_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !snp_mask[rsp_core]);
  // R2: a miss is never accompanied by a snoop
  a_r2_miss_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> !snp_valid);
  // R7: back-invalidates only come with a miss that replaced a valid line
  a_r7_binv_on_evict: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> (rsp_valid && !rsp_hit && rsp_evict));
  // R9: acceptance makes the port busy on the next cycle
  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9: the response is a single-cycle pulse issued while busy
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_pulse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || snp_valid || binv_valid) |-> !req_ready);
endmodule

// File: tb/cache_presence_dir_bench.sv
module cache_presence_dir_bench;
  localparam int NC = 4, SETS = 4, WAYS = 2, AW = 12, OW = 4, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_excl = 1'b0;
  logic [1:0] req_core = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, snp_valid, snp_inv, binv_valid, rsp_valid, rsp_hit, rsp_evict;
  logic [NC-1:0] snp_mask, binv_mask;
  logic [AW-1:0] snp_addr, binv_addr;
  logic [1:0] rsp_core;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  bit       m_val  [SETS][WAYS];
  int       m_tag  [SETS][WAYS];
  bit [3:0] m_pres [SETS][WAYS];
  int       m_used [SETS][WAYS];
  int       tick = 0;
  logic [AW-1:0] last_binv_addr;
  logic          last_hit;

  always #2.5 clk = ~clk;

  cache_presence_dir #(.NCORES(NC), .SETS(SETS), .WAYS(WAYS), .ADDR_W(AW), .OFF_W(OW)) u_cache_presence_dir (
    .clk, .rst_n, .req_valid, .req_ready, .req_core, .req_addr, .req_excl,
    .snp_valid, .snp_mask, .snp_inv, .snp_addr,
    .binv_valid, .binv_mask, .binv_addr,
    .rsp_valid, .rsp_core, .rsp_hit, .rsp_evict
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int set_of(input int a); return (a >> OW) % SETS; endfunction
  function automatic int tag_of(input int a); return a >> (OW + SW); endfunction

  task automatic do_req(input int core, input int addr, input bit excl);
    int s, t, way, v;
    bit hit, e_evict, e_binv, e_snp;
    bit [3:0] self, others, e_bmask;
    int e_baddr;
    s = set_of(addr); t = tag_of(addr); self = 4'(1 << core);
    hit = 1'b0; way = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_val[s][w] && m_tag[s][w] == t) begin hit = 1'b1; way = w; end
    others = hit ? (m_pres[s][way] & ~self) : 4'b0;
    e_snp = hit && (others != 0);
    e_evict = 1'b0; e_binv = 1'b0; e_bmask = '0; e_baddr = 0;
    if (!hit) begin
      v = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) v = w;
      if (v < 0) begin
        v = 0;
        for (int w = 1; w < WAYS; w++) if (m_used[s][w] < m_used[s][v]) v = w;
      end
      way = v;
      e_evict = m_val[s][v];
      e_bmask = m_pres[s][v];
      e_binv  = e_evict && (e_bmask != 0);
      e_baddr = (m_tag[s][v] << (OW + SW)) | (s << OW);
    end

    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(core); req_addr = AW'(addr); req_excl = excl;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready during lookup", req_ready, 0);
    chk(rsp_valid == 1'b0, "R9", "early response", rsp_valid, 0);
    @(negedge clk);
    chk(req_ready == 1'b0 && rsp_valid == 1'b1, "R9", "response pulse {ready,valid}",
        {req_ready, rsp_valid}, 2'b01);
    chk(rsp_core == 2'(core), "R9", "rsp_core", rsp_core, core);
    chk(rsp_hit == hit, hit ? (excl ? "R4" : "R3") : "R2", "rsp_hit", rsp_hit, hit);
    chk(snp_valid == e_snp, "R5", "snp_valid", snp_valid, e_snp);
    if (e_snp) begin
      chk(snp_mask == others, excl ? "R4" : "R3", "snp_mask", snp_mask, others);
      chk(snp_inv == excl, excl ? "R4" : "R3", "snp_inv", snp_inv, excl);
      chk(snp_addr == AW'(addr), "R5", "snp_addr", snp_addr, addr);
    end
    chk(rsp_evict == e_evict, "R8", "rsp_evict", rsp_evict, e_evict);
    chk(binv_valid == e_binv, "R7", "binv_valid", binv_valid, e_binv);
    if (e_binv) begin
      chk(binv_mask == e_bmask, "R7", "binv_mask", binv_mask, e_bmask);
      chk(binv_addr == AW'(e_baddr), "R6", "binv_addr (victim line)", binv_addr, e_baddr);
    end
    last_binv_addr = binv_addr; last_hit = rsp_hit;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1 && snp_valid == 1'b0 && binv_valid == 1'b0,
        "R9", "pulse ends and port idle", {rsp_valid, req_ready, snp_valid, binv_valid}, 4'b0100);

    tick++;
    m_used[s][way] = tick;
    if (hit) m_pres[s][way] = excl ? self : (m_pres[s][way] | self);
    else begin m_val[s][way] = 1'b1; m_tag[s][way] = t; m_pres[s][way] = self; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int a_line, b_line, c_line, d_line;
    void'($urandom(32'd2718));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 1'b0; m_tag[s][w] = 0; m_pres[s][w] = '0; m_used[s][w] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({rsp_valid, snp_valid, binv_valid} == 3'b000, "R1", "pulses after reset",
        {rsp_valid, snp_valid, binv_valid}, 0);

    a_line = (1 << (OW + SW)); b_line = (2 << (OW + SW));
    c_line = (3 << (OW + SW)); d_line = (4 << (OW + SW));
    do_req(0, a_line + 3, 1'b0);
    chk(last_hit == 1'b0, "R1", "first access misses", last_hit, 0);
    do_req(0, a_line + 9, 1'b0);               // sole holder re-reads: no snoop (R5)
    chk(last_hit == 1'b1, "R10", "other offset of same line hits", last_hit, 1);
    do_req(1, a_line + 15, 1'b0);              // R3 snoop core0
    do_req(2, a_line, 1'b1);                   // R4 snoop cores 0,1 invalidating
    do_req(3, a_line + 1, 1'b0);               // R4 leaves only core2: mask 0100
    do_req(0, b_line, 1'b0);                   // fills way 1, no eviction (R6)
    do_req(1, a_line, 1'b0);                   // A most recent
    do_req(0, c_line + 2, 1'b0);               // B is LRU and replaced
    chk(last_binv_addr == AW'(b_line), "R6", "least recent line replaced", last_binv_addr, b_line);
    do_req(2, d_line, 1'b1);                   // A replaced, holders 1110 (R7)
    chk(last_binv_addr == AW'(a_line), "R7", "multi-holder line back-invalidated", last_binv_addr, a_line);

    for (int i = 0; i < 500; i++) begin
      int addr;
      addr = (($urandom % 5) << (OW + SW)) | (($urandom % SETS) << OW) | ($urandom % (1 << OW));
      do_req(int'($urandom % NC), addr, 1'($urandom % 3 == 0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule